// File: doc/BRIEF.md
# Rollback Log for Out-of-Order Register Writeback

This block keeps a program-ordered log of every decoded instruction so that the register file can take results in any order and the machine can still stop at an exact instruction when one of them faults. At decode each instruction claims the next slot of a circular log. With that slot it leaves its destination register number, the value that register holds at that moment, and its own PC. The slot number is handed back as a tag. Functional units then write the register file directly and report completion against that tag, marking whether the operation faulted.

A completed, fault-free instruction at the oldest slot simply leaves the log: nothing is written anywhere. When the oldest slot completes with a fault, decode is held off. The block then walks the slots younger than the faulting one, from the youngest back towards the oldest, one per cycle, and writes each logged old value back into its register through a dedicated write port. At the end the whole log is emptied and the faulting PC is presented for the handler. An instruction without a destination still takes a slot, but its slot produces no write during a walk. DEPTH must be a power of two.

Top module: `hist_buf`

## Requirements
- R1: After reset, alloc_ready is 1, alloc_tag is 0, and busy, rf_we, retire_ok and exc_valid are all 0.
- R2: A slot is taken at a clock edge where alloc_valid and alloc_ready are both 1; alloc_tag shows the slot that the next accepted instruction will take, and successive instructions get successive tags modulo DEPTH.
- R3: While DEPTH slots are live, alloc_ready is 0 and alloc_valid is ignored: no slot is taken and alloc_tag does not move.
- R4: Completions may arrive in any order, but slots leave only from the oldest end and only once completed; if the completion of the oldest slot is sampled at edge 1, retire_ok is 1 after edge 2, and already-completed younger slots follow at one per cycle.
- R5: A normal retirement never asserts rf_we.
- R6: When the oldest slot completes with cpl_exc = 1 (completion sampled at edge 1), the slots younger than it are restored youngest first: the k-th youngest (k = 0 for the youngest) drives rf_we = 1 with its logged register and old value after edge 4+k. The faulting slot itself is not restored.
- R7: A slot allocated with alloc_has_dst = 0 produces no write in its restore cycle.
- R8: From edge 2 of a fault until the walk ends, busy is 1 and alloc_ready is 0.
- R9: With n younger slots, exc_valid is a one-cycle pulse after edge n+3 while exc_pc holds the faulting slot's PC; at that point busy is 0, the log is empty and alloc_tag is 0.
- R10: A faulting slot that is not yet the oldest waits; older slots retire normally first, and the walk starts one edge after the last of them leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Decode presents an instruction |
| alloc_has_dst | input | 1 | Instruction writes a register |
| alloc_dst | input | $clog2(NREG) | Destination register number |
| alloc_old | input | DW | Current value of the destination register |
| alloc_pc | input | PCW | Instruction PC |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | $clog2(DEPTH) | Slot the next accepted instruction takes |
| cpl_valid | input | 1 | A functional unit reports completion |
| cpl_tag | input | $clog2(DEPTH) | Slot of the completing instruction |
| cpl_exc | input | 1 | The completing instruction faulted |
| retire_ok | output | 1 | One slot left the log normally |
| busy | output | 1 | Rollback walk in progress |
| rf_we | output | 1 | Restore write enable |
| rf_waddr | output | $clog2(NREG) | Restore register number |
| rf_wdata | output | DW | Restored old value |
| exc_valid | output | 1 | Rollback finished, fault reported |
| exc_pc | output | PCW | PC of the faulting instruction |

## Verification
Every result has a fixed distance from the completion edge that causes it: a retirement shows two edges later, the k-th restore write 4+k edges later and the fault report n+3 edges later, shifted by one edge when the fault waits behind an older retirement. The bench drives and samples on falling edges and counts exactly that many falling edges before looking at busy, retire_ok, alloc_ready and exc_valid. Restore writes are matched by a scoreboard that the fault task fills, youngest first and skipping slots without a destination, so a missing, extra or reordered write shows up as a miscompare.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WALK  = 2'd1,
    HB_DRAIN = 2'd2
  } hb_state_e;
endpackage

// File: rtl/hb_ring_ptr.sv
module hb_ring_ptr #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  output logic [IW-1:0] head,
  output logic [IW-1:0] head_nxt,
  output logic [IW-1:0] tail,
  output logic [IW:0]   cnt,
  output logic          full
);
  localparam logic [IW-1:0] ONE_I = 1;
  localparam logic [IW:0]   ONE_C = 1;
  localparam logic [IW:0]   DEP_C = DEPTH;

  assign full     = (cnt == DEP_C);
  assign head_nxt = flush ? '0 : (pop ? head + ONE_I : head);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (push) tail <= tail + ONE_I;
      if (pop)  head <= head + ONE_I;
      case ({push, pop})
        2'b10:   cnt <= cnt + ONE_C;
        2'b01:   cnt <= cnt - ONE_C;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/hb_entry_ram.sv
module hb_entry_ram #(
  parameter int DEPTH = 8,
  parameter int W     = 70,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hb_flags.sv
module hb_flags #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          cpl_en,
  input  logic [IW-1:0] cpl_idx,
  input  logic          cpl_exc,
  input  logic          ret_en,
  input  logic [IW-1:0] head_idx,
  output logic          h_valid,
  output logic          h_done,
  output logic          h_exc
);
  logic [DEPTH-1:0] live_q, done_q, bad_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      live_q <= '0;
      done_q <= '0;
      bad_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (set_en && set_idx == IW'(i)) begin
          live_q[i] <= 1'b1;
          done_q[i] <= 1'b0;
          bad_q[i]  <= 1'b0;
        end else if (ret_en && head_idx == IW'(i)) begin
          live_q[i] <= 1'b0;
        end else if (cpl_en && cpl_idx == IW'(i) && live_q[i]) begin
          done_q[i] <= 1'b1;
          bad_q[i]  <= cpl_exc;
        end
      end
    end
  end

  assign h_valid = live_q[head_idx];
  assign h_done  = done_q[head_idx];
  assign h_exc   = bad_q[head_idx];
endmodule

// File: rtl/hist_buf.sv
module hist_buf
  import hb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREG  = 32,
  parameter int DW    = 32,
  parameter int PCW   = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alloc_valid,
  input  logic           alloc_has_dst,
  input  logic [RW-1:0]  alloc_dst,
  input  logic [DW-1:0]  alloc_old,
  input  logic [PCW-1:0] alloc_pc,
  output logic           alloc_ready,
  output logic [IW-1:0]  alloc_tag,
  input  logic           cpl_valid,
  input  logic [IW-1:0]  cpl_tag,
  input  logic           cpl_exc,
  output logic           retire_ok,
  output logic           busy,
  output logic           rf_we,
  output logic [RW-1:0]  rf_waddr,
  output logic [DW-1:0]  rf_wdata,
  output logic           exc_valid,
  output logic [PCW-1:0] exc_pc
);
  localparam int EW = 1 + RW + DW + PCW;
  localparam logic [IW-1:0] ONE_I = 1;
  localparam logic [IW:0]   ONE_C = 1;

  hb_state_e state_q;
  logic [IW-1:0] head, head_nxt, tail, walk_q, raddr;
  logic [IW:0]   cnt, left_q;
  logic          full, push, flush, fault, retire;
  logic          h_valid, h_done, h_exc;
  logic [EW-1:0] wr_ent, rd_ent;
  logic          rd_has;
  logic [RW-1:0] rd_dst;
  logic [DW-1:0] rd_old;
  logic [PCW-1:0] rd_pc;
  logic          iss_q, rf_we_q, exc_q, ret_q;
  logic [RW-1:0] rf_addr_q;
  logic [DW-1:0] rf_data_q;
  logic [PCW-1:0] pc_q;

  // slot bookkeeping: head/tail ring and per-slot status bits
  assign fault  = (state_q == HB_IDLE) && h_valid && h_done && h_exc;
  assign retire = (state_q == HB_IDLE) && h_valid && h_done && !h_exc;
  assign flush  = (state_q == HB_DRAIN);
  assign alloc_ready = (state_q == HB_IDLE) && !full && !fault;
  assign push   = alloc_valid && alloc_ready;
  assign alloc_tag = tail;

  hb_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .push(push), .pop(retire), .flush(flush),
    .head(head), .head_nxt(head_nxt), .tail(tail), .cnt(cnt), .full(full)
  );

  hb_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .clr(flush),
    .set_en(push), .set_idx(tail),
    .cpl_en(cpl_valid), .cpl_idx(cpl_tag), .cpl_exc(cpl_exc),
    .ret_en(retire), .head_idx(head),
    .h_valid(h_valid), .h_done(h_done), .h_exc(h_exc)
  );

  // write-once payload in a synchronous-read array; while idle it
  // pre-reads the next head so the faulting PC is ready on detection
  assign wr_ent = {alloc_has_dst, alloc_dst, alloc_old, alloc_pc};
  assign raddr  = (state_q == HB_WALK) ? walk_q : head_nxt;

  hb_entry_ram #(.DEPTH(DEPTH), .W(EW)) u_ram (
    .clk(clk), .we(push), .waddr(tail), .wdata(wr_ent),
    .raddr(raddr), .rdata(rd_ent)
  );

  assign {rd_has, rd_dst, rd_old, rd_pc} = rd_ent;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= HB_IDLE;
      walk_q    <= '0;
      left_q    <= '0;
      iss_q     <= 1'b0;
      rf_we_q   <= 1'b0;
      rf_addr_q <= '0;
      rf_data_q <= '0;
      exc_q     <= 1'b0;
      ret_q     <= 1'b0;
      pc_q      <= '0;
    end else begin
      iss_q   <= (state_q == HB_WALK);
      rf_we_q <= iss_q && rd_has;
      if (iss_q) begin
        rf_addr_q <= rd_dst;
        rf_data_q <= rd_old;
      end
      exc_q <= (state_q == HB_DRAIN);
      ret_q <= retire;
      case (state_q)
        HB_IDLE: begin
          if (fault) begin
            pc_q    <= rd_pc;
            walk_q  <= tail - ONE_I;
            left_q  <= cnt - ONE_C;
            state_q <= (cnt == ONE_C) ? HB_DRAIN : HB_WALK;
          end
        end
        HB_WALK: begin
          walk_q <= walk_q - ONE_I;
          left_q <= left_q - ONE_C;
          if (left_q == ONE_C) state_q <= HB_DRAIN;
        end
        default: state_q <= HB_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != HB_IDLE);
  assign retire_ok = ret_q;
  assign rf_we     = rf_we_q;
  assign rf_waddr  = rf_addr_q;
  assign rf_wdata  = rf_data_q;
  assign exc_valid = exc_q;
  assign exc_pc    = pc_q;
endmodule

// File: rtl/hb_chk.sv
module hb_chk #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        alloc_ready,
  input logic        rf_we,
  input logic        exc_valid,
  input logic        retire_ok,
  input logic [IW:0] cnt
);
  localparam logic [IW:0] DEP_C = DEPTH;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= DEP_C);
  p_full_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == DEP_C) |-> !alloc_ready);
  p_retire_silent_r5: assert property (@(posedge clk) disable iff (rst)
    retire_ok |-> !rf_we);
  p_restore_in_walk_r6: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(busy));
  p_decode_held_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !alloc_ready);
  p_exc_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> !exc_valid);
  p_exc_ends_walk_r9: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> ($past(busy) && !busy));
endmodule

bind hist_buf hb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .alloc_ready(alloc_ready),
  .rf_we(rf_we), .exc_valid(exc_valid), .retire_ok(retire_ok), .cnt(cnt)
);

// File: tb/sim_hist_buf.sv
module sim_hist_buf;
  localparam int D = 8, NR = 32, DW = 32, PW = 32;
  localparam int IW = $clog2(D), RW = $clog2(NR);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, alloc_valid, alloc_has_dst, alloc_ready, cpl_valid, cpl_exc;
  logic [RW-1:0] alloc_dst, rf_waddr;
  logic [DW-1:0] alloc_old, rf_wdata;
  logic [PW-1:0] alloc_pc, exc_pc;
  logic [IW-1:0] alloc_tag, cpl_tag;
  logic retire_ok, busy, rf_we, exc_valid;

  hist_buf #(.DEPTH(D), .NREG(NR), .DW(DW), .PCW(PW)) u0 (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_has_dst(alloc_has_dst),
    .alloc_dst(alloc_dst), .alloc_old(alloc_old), .alloc_pc(alloc_pc),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag), .cpl_valid(cpl_valid),
    .cpl_tag(cpl_tag), .cpl_exc(cpl_exc), .retire_ok(retire_ok), .busy(busy),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .exc_valid(exc_valid), .exc_pc(exc_pc)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [RW-1:0] q_addr[$];
  logic [DW-1:0] q_data[$];
  logic [PW-1:0] q_pc[$];
  logic          m_hd[D];
  logic [RW-1:0] m_dst[D];
  logic [DW-1:0] m_old[D];
  logic [PW-1:0] m_pc[D];
  int m_head = 0, m_cnt = 0, n_ret = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual %0d cycles expected under 20000", cyc);
      finish_run();
    end
  end

  // monitor: scoreboard for restore writes, retirements and fault report
  always @(negedge clk) begin : mon
    logic [RW-1:0] ea;
    logic [DW-1:0] ed;
    logic [PW-1:0] ep;
    if (!rst) begin
      if (rf_we) begin
        if (q_addr.size() == 0) chk(1'b0, "R7", "unexpected restore write", 64'(rf_waddr), 0);
        else begin
          ea = q_addr.pop_front();
          ed = q_data.pop_front();
          chk(rf_waddr == ea, "R6", "restore register", 64'(rf_waddr), 64'(ea));
          chk(rf_wdata == ed, "R6", "restore value", 64'(rf_wdata), 64'(ed));
        end
      end
      if (retire_ok) begin
        chk(!rf_we, "R5", "write during retirement", 64'(rf_we), 0);
        m_head = (m_head + 1) % D;
        m_cnt--;
        n_ret++;
      end
      if (exc_valid) begin
        if (q_pc.size() == 0) chk(1'b0, "R9", "unexpected fault report", 64'(exc_pc), 0);
        else begin
          ep = q_pc.pop_front();
          chk(exc_pc == ep, "R9", "faulting PC", 64'(exc_pc), 64'(ep));
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic alloc(input logic hd, input logic [RW-1:0] dst,
                       input logic [DW-1:0] old, input logic [PW-1:0] pc);
    int slot;
    slot = (m_head + m_cnt) % D;
    chk(alloc_ready == 1'b1, "R2", "slot available", 64'(alloc_ready), 1);
    chk(alloc_tag == IW'(slot), "R2", "allocated tag", 64'(alloc_tag), 64'(slot));
    alloc_valid = 1'b1; alloc_has_dst = hd; alloc_dst = dst;
    alloc_old = old; alloc_pc = pc;
    m_hd[slot] = hd; m_dst[slot] = dst; m_old[slot] = old; m_pc[slot] = pc;
    m_cnt++;
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic complete(input int slot, input logic exc);
    cpl_valid = 1'b1; cpl_tag = IW'(slot % D); cpl_exc = exc;
    tick();
    cpl_valid = 1'b0; cpl_exc = 1'b0;
  endtask

  // push expected restores (youngest first) and the faulting PC
  task automatic expect_rollback(input int fslot, input int younger);
    for (int k = younger; k >= 1; k--) begin
      int s;
      s = (fslot + k) % D;
      if (m_hd[s]) begin
        q_addr.push_back(m_dst[s]);
        q_data.push_back(m_old[s]);
      end
    end
    q_pc.push_back(m_pc[fslot]);
  endtask

  task automatic fault_head();
    int n;
    n = m_cnt - 1;
    expect_rollback(m_head, n);
    complete(m_head, 1'b1);
    tick();
    chk(busy == 1'b1, "R8", "busy after fault", 64'(busy), 1);
    chk(alloc_ready == 1'b0, "R8", "decode held", 64'(alloc_ready), 0);
    repeat (n) tick();
    chk(exc_valid == 1'b0, "R9", "report not early", 64'(exc_valid), 0);
    tick();
    chk(exc_valid == 1'b1, "R9", "report at n+3", 64'(exc_valid), 1);
    chk(busy == 1'b0, "R9", "walk ended", 64'(busy), 0);
    chk(alloc_tag == '0, "R9", "log emptied", 64'(alloc_tag), 0);
    chk(q_addr.size() == 0, "R6", "all restores seen", 64'(q_addr.size()), 0);
    m_head = 0; m_cnt = 0;
    tick();
    chk(exc_valid == 1'b0, "R9", "report is one cycle", 64'(exc_valid), 0);
  endtask

  initial begin
    rst = 1'b1; alloc_valid = 0; alloc_has_dst = 0; alloc_dst = '0;
    alloc_old = '0; alloc_pc = '0; cpl_valid = 0; cpl_tag = '0; cpl_exc = 0;
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(alloc_ready == 1'b1, "R1", "alloc_ready", 64'(alloc_ready), 1);
    chk(alloc_tag == '0, "R1", "alloc_tag", 64'(alloc_tag), 0);
    chk({busy, rf_we, retire_ok, exc_valid} == 4'b0, "R1", "idle outputs",
        64'({busy, rf_we, retire_ok, exc_valid}), 0);

    // R4/R5: younger done first, head blocks, then burst retirement
    alloc(1, 5'd3, 32'h11, 32'h100);
    alloc(1, 5'd4, 32'h22, 32'h104);
    alloc(0, 5'd0, 32'h0, 32'h108);
    complete(2, 1'b0);
    complete(1, 1'b0);
    tick();
    chk(retire_ok == 1'b0, "R4", "no retire before head done", 64'(retire_ok), 0);
    complete(0, 1'b0);
    chk(retire_ok == 1'b0, "R4", "retire not early", 64'(retire_ok), 0);
    tick();
    chk(retire_ok == 1'b1, "R4", "first retire", 64'(retire_ok), 1);
    tick();
    chk(retire_ok == 1'b1, "R4", "second retire", 64'(retire_ok), 1);
    tick();
    chk(retire_ok == 1'b1, "R4", "third retire", 64'(retire_ok), 1);
    tick();
    chk(retire_ok == 1'b0, "R4", "retire stops", 64'(retire_ok), 0);
    chk(n_ret == 3 && m_cnt == 0, "R4", "retired count", 64'(n_ret), 3);

    // R3: fill (wraps the ring), blocked alloc ignored, then drain
    for (int i = 0; i < D; i++) alloc(1, 5'(i + 8), 32'h500 + i, 32'h200 + 4 * i);
    chk(alloc_ready == 1'b0, "R3", "full stalls decode", 64'(alloc_ready), 0);
    alloc_valid = 1'b1; alloc_pc = 32'hdead;
    tick();
    alloc_valid = 1'b0;
    chk(alloc_tag == IW'(m_head), "R3", "tag unmoved when full", 64'(alloc_tag), 64'(m_head));
    chk(alloc_ready == 1'b0, "R3", "still full", 64'(alloc_ready), 0);
    for (int i = D - 1; i >= 1; i--) complete(m_head + i, 1'b0);
    complete(m_head, 1'b0);
    repeat (D + 2) tick();
    chk(m_cnt == 0 && n_ret == 3 + D, "R4", "full drain", 64'(n_ret), 64'(3 + D));

    // R6/R7/R8/R9: fault at head with four younger slots, one without dst
    alloc(1, 5'd1, 32'haaaa0001, 32'h300);
    alloc(1, 5'd2, 32'haaaa0002, 32'h304);
    alloc(0, 5'd9, 32'hbad, 32'h308);
    alloc(1, 5'd2, 32'haaaa0004, 32'h30c);
    alloc(1, 5'd7, 32'haaaa0005, 32'h310);
    complete(m_head + 3, 1'b0);
    complete(m_head + 1, 1'b0);
    complete(m_head + 4, 1'b0);
    complete(m_head + 2, 1'b0);
    fault_head();

    // R9: lone faulting slot, no restores
    alloc(1, 5'd6, 32'h66, 32'h400);
    fault_head();

    // R10: fault behind an older slot
    alloc(1, 5'd10, 32'hc0, 32'h500);
    alloc(1, 5'd11, 32'hc1, 32'h504);
    alloc(1, 5'd12, 32'hc2, 32'h508);
    alloc(0, 5'd13, 32'hc3, 32'h50c);
    complete(1, 1'b1);
    complete(2, 1'b0);
    tick();
    chk(busy == 1'b0 && retire_ok == 1'b0, "R10", "younger fault waits", 64'(busy), 0);
    expect_rollback(1, 2);
    complete(0, 1'b0);
    tick();
    chk(retire_ok == 1'b1, "R10", "older slot retires", 64'(retire_ok), 1);
    tick();
    chk(busy == 1'b1, "R10", "walk starts", 64'(busy), 1);
    repeat (2) tick();
    chk(exc_valid == 1'b0, "R10", "report not early", 64'(exc_valid), 0);
    tick();
    chk(exc_valid == 1'b1, "R10", "report after walk", 64'(exc_valid), 1);
    chk(q_addr.size() == 0, "R10", "restores seen", 64'(q_addr.size()), 0);
    m_head = 0; m_cnt = 0;
    tick();
    chk(alloc_ready == 1'b1 && alloc_tag == '0, "R2", "usable after rollback",
        64'(alloc_tag), 0);
    finish_run();
  end
endmodule